// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel flash. It waits for the flash to finish an internal program or erase by reading the status bit repeatedly. A single-cycle start pulse loads three things: the operation kind, the address to poll, and, for a program, the byte that was written. The block then issues reads on a simple synchronous read port, one read at a time, and leaves a fixed number of idle cycles after each returned word.

A status read that shows completion does not end the operation on its own. The top bit of the flash can turn valid before the seven lower bits do. For that reason the block issues one extra confirmation read and takes the final byte from it. For a program, that byte is compared with the expected byte. If no completion shows up within a configured number of status reads, the block gives up and raises a timeout. The outcome is signalled by a one-cycle done pulse. The result flags and the final byte stay on the outputs until the next accepted start.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, busy_o, rd_req_o and done_o are low and no read is issued until a start is accepted.
- R2: A start accepted while idle causes the first read in the following cycle. Every read of the operation carries the address given with that start: the programmed location for a program, or a location inside an erased sector for an erase.
- R3: op_i selects the completion test, with 0 meaning program and 1 meaning erase. A program status read completes when data bit 7 equals bit 7 of the expected byte. An erase status read completes when data bit 7 is 1.
- R4: After a completing status read, exactly one further read is issued. done_o follows that confirmation read, and result_data_o holds the byte returned by that read.
- R5: For a program, a confirmation byte equal to the whole expected byte gives pass_o=1 and mismatch_o=0. Any other confirmation byte gives pass_o=0 and mismatch_o=1.
- R6: For an erase, the confirmation read always ends with pass_o=1, mismatch_o=0 and timeout_o=0.
- R7: After each returned read word, rd_req_o stays low for exactly GAP_CYCLES cycles before the next read is requested.
- R8: If MAX_POLLS status reads in a row fail the completion test, the operation ends with timeout_o=1 and pass_o=0, and no further read is issued.
- R9: A start pulse while busy_o is high is ignored. The address, timing and result of the running operation do not change.
- R10: done_o is high for exactly one cycle, in the cycle after the final read word is accepted, and busy_o is low in that cycle. Exactly one of pass_o, timeout_o and mismatch_o is high from then until the next accepted start.
- R11: At most one read is outstanding. rd_req_o is not raised again until the data of the previous read has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; only honoured while idle |
| op_i | input | 1 | 0 = program, 1 = erase |
| addr_i | input | AW | Address to poll |
| data_i | input | 8 | Expected byte for a program |
| busy_o | output | 1 | An operation is being tracked |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed with correct data |
| timeout_o | output | 1 | Poll limit reached without completion |
| mismatch_o | output | 1 | Program completed but the byte differs |
| result_data_o | output | 8 | Last byte read for the operation |

## Verification
The hardest case to reach from the ports is the stale-byte read: the top bit already shows completion while the lower seven bits still hold leftover status. A design that stops at that read would report a wrong byte. The bench's flash model returns this read deliberately, with lower bits that are the inverse of the true data, right after a chosen number of busy reads. It then returns the true byte (or a corrupted one) only on later reads. Busy-read counts of zero, one below the poll limit, and above it drive the first-read hit, the last-chance hit and the timeout. An intruding start pulse is injected mid-operation.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_GAP
    } state_e;

    typedef struct packed {
        logic       pass;
        logic       timeout;
        logic       mismatch;
        logic [7:0] data;
    } result_t;

    function automatic logic top_bit_done(op_e op, logic [7:0] expect_b, logic [7:0] rd);
        if (op == OP_ERASE) return rd[7];
        return rd[7] == expect_b[7];
    endfunction

endpackage

// File: rtl/fdp_status_eval.sv
module fdp_status_eval
    import fdp_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] expect_b,
    input  logic [7:0] rd_data,
    output logic       hit,
    output logic       byte_ok
);
    always_comb begin
        hit     = top_bit_done(op, expect_b, rd_data);
        byte_ok = (op == OP_ERASE) ? 1'b1 : (rd_data == expect_b);
    end
endmodule

// File: rtl/fdp_gap_timer.sv
module fdp_gap_timer #(
    parameter int GAP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= GW'(GAP_CYCLES - 1);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fdp_poll_counter.sv
module fdp_poll_counter #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic at_last
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (bump)    cnt <= cnt + 1'b1;
    end

    assign at_last = (cnt == PW'(MAX_POLLS - 1));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= PW'(MAX_POLLS));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fdp_pkg::*;
#(
    parameter int AW         = 24,
    parameter int MAX_POLLS  = 4096,
    parameter int GAP_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic          busy_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [7:0]    rd_data_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          timeout_o,
    output logic          mismatch_o,
    output logic [7:0]    result_data_o
);
    state_e        state;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    expect_q;
    logic          confirm_q;
    logic          done_q;
    result_t       res_q;

    logic hit, byte_ok, gap_expired, last_poll;
    logic accept, word_in, fail_read;

    assign accept    = (state == ST_IDLE) && start_i;
    assign word_in   = (state == ST_WAIT) && rd_valid_i;
    assign fail_read = word_in && !confirm_q && !hit;

    fdp_status_eval u_eval (
        .op      (op_q),
        .expect_b(expect_q),
        .rd_data (rd_data_i),
        .hit     (hit),
        .byte_ok (byte_ok)
    );

    fdp_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .load   (word_in),
        .expired(gap_expired)
    );

    fdp_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .bump   (fail_read),
        .at_last(last_poll)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= OP_PROGRAM;
            addr_q    <= '0;
            expect_q  <= '0;
            confirm_q <= 1'b0;
            done_q    <= 1'b0;
            res_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start_i) begin
                    op_q      <= op_e'(op_i);
                    addr_q    <= addr_i;
                    expect_q  <= data_i;
                    confirm_q <= 1'b0;
                    res_q     <= '0;
                    state     <= ST_ISSUE;
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: if (rd_valid_i) begin
                    if (confirm_q) begin
                        res_q  <= '{pass: byte_ok, timeout: 1'b0,
                                    mismatch: !byte_ok, data: rd_data_i};
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (hit) begin
                        confirm_q <= 1'b1;
                        state     <= ST_GAP;
                    end else if (last_poll) begin
                        res_q  <= '{pass: 1'b0, timeout: 1'b1,
                                    mismatch: 1'b0, data: rd_data_i};
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP: if (gap_expired) state <= ST_ISSUE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o        = (state != ST_IDLE);
    assign rd_req_o      = (state == ST_ISSUE);
    assign rd_addr_o     = addr_q;
    assign done_o        = done_q;
    assign pass_o        = res_q.pass;
    assign timeout_o     = res_q.timeout;
    assign mismatch_o    = res_q.mismatch;
    assign result_data_o = res_q.data;

    // R11: a request is never followed directly by another one
    a_r11_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o);

    // R7: a returned word is always followed by at least one idle cycle
    a_r7_idle_after_word: assert property (@(posedge clk) disable iff (rst)
        word_in |=> !rd_req_o);

    // R10: done is a single-cycle pulse and the block is idle with it
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones({pass_o, timeout_o, mismatch_o}) == 1));

    // R9: the polled address cannot move while an operation runs
    a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

    // R1: nothing is requested while idle
    a_r1_no_idle_read: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !rd_req_o);
endmodule

// File: tb/sim_flash_done_poller.sv
module sim_flash_done_poller;
    localparam int AW   = 16;
    localparam int MAXP = 6;
    localparam int GAP  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          op_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic          rd_valid_i = 1'b0;
    logic [7:0]    rd_data_i = 8'h00;
    logic          busy_o, rd_req_o, done_o, pass_o, timeout_o, mismatch_o;
    logic [AW-1:0] rd_addr_o;
    logic [7:0]    result_data_o;

    always #5 clk = ~clk;

    flash_done_poller #(.AW(AW), .MAX_POLLS(MAXP), .GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .data_i(data_i), .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .done_o(done_o),
        .pass_o(pass_o), .timeout_o(timeout_o), .mismatch_o(mismatch_o),
        .result_data_o(result_data_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // scenario and model state
    logic          m_op = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [7:0]    m_exp = '0;
    int            m_busy_n = 0;
    int            m_lat = 1;
    bit            m_corrupt = 1'b0;
    int            next_req = -1;
    int            exp_done = -1;
    int            resp_cyc = -1;
    int            resp_idx = 0;
    int            n_reads = 0;
    int            n_fail = 0;
    bit            m_confirm = 1'b0;
    bit            done_seen = 1'b0;
    logic [7:0]    resp_data = '0;
    bit            e_pass, e_to, e_mm;
    logic [7:0]    e_data;

    function automatic logic [7:0] true_byte();
        if (m_op) return 8'hFF;
        return m_corrupt ? (m_exp ^ 8'h01) : m_exp;
    endfunction

    function automatic logic [7:0] flash_word(int k);
        logic [7:0] t;
        t = true_byte();
        if (k < m_busy_n) return {(m_op ? 1'b0 : ~m_exp[7]), ~t[6:0]};
        if (k == m_busy_n) return {t[7], ~t[6:0]};
        return t;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            chk(rd_req_o === (cyc == next_req), "R7 R11 R2 read request timing",
                rd_req_o, (cyc == next_req));
            if (rd_req_o) begin
                chk(rd_addr_o === m_addr, "R2 R9 read address", rd_addr_o, m_addr);
                resp_cyc  = cyc + m_lat;
                resp_idx  = n_reads;
                resp_data = flash_word(n_reads);
                n_reads++;
            end
            chk(done_o === (cyc == exp_done), "R10 done pulse", done_o, (cyc == exp_done));
            if (cyc == exp_done) begin
                chk(busy_o === 1'b0, "R10 idle with done", busy_o, 0);
                chk(pass_o === e_pass, "R5 R6 pass flag", pass_o, e_pass);
                chk(timeout_o === e_to, "R8 timeout flag", timeout_o, e_to);
                chk(mismatch_o === e_mm, "R5 mismatch flag", mismatch_o, e_mm);
                if (!e_to) chk(result_data_o === e_data, "R4 confirmation byte", result_data_o, e_data);
                done_seen = 1'b1;
            end
            if (cyc == resp_cyc) begin
                rd_valid_i = 1'b1;
                rd_data_i  = resp_data;
                if (m_confirm) begin
                    exp_done = cyc + 1;
                    e_to     = 1'b0;
                    e_pass   = m_op ? 1'b1 : !m_corrupt;
                    e_mm     = m_op ? 1'b0 : m_corrupt;
                    e_data   = true_byte();
                end else if (resp_idx >= m_busy_n) begin
                    m_confirm = 1'b1;
                    next_req  = cyc + GAP + 1;
                end else begin
                    n_fail++;
                    if (n_fail == MAXP) begin
                        exp_done = cyc + 1;
                        e_to = 1'b1; e_pass = 1'b0; e_mm = 1'b0;
                    end else begin
                        next_req = cyc + GAP + 1;
                    end
                end
            end else begin
                rd_valid_i = 1'b0;
                rd_data_i  = 8'hA5;
            end
        end
    end

    task automatic run_op(input logic op, input logic [AW-1:0] addr, input logic [7:0] exp,
                          input int busy_n, input int lat, input bit corrupt, input bit intrude);
        int wd;
        @(negedge clk);
        m_op = op; m_addr = addr; m_exp = exp; m_busy_n = busy_n; m_lat = lat;
        m_corrupt = corrupt; n_reads = 0; n_fail = 0; m_confirm = 1'b0;
        exp_done = -1; resp_cyc = -1; done_seen = 1'b0;
        next_req = cyc + 1;
        start_i = 1'b1; op_i = op; addr_i = addr; data_i = exp;
        @(negedge clk);
        start_i = 1'b0; addr_i = '0; data_i = 8'h00;
        if (intrude) begin
            repeat (3) @(negedge clk);
            chk(busy_o === 1'b1, "R9 busy during operation", busy_o, 1);
            start_i = 1'b1; op_i = ~op; addr_i = ~addr; data_i = ~exp;
            @(negedge clk);
            start_i = 1'b0;
        end
        wd = 0;
        while (!done_seen && wd < 2000) begin
            @(negedge clk);
            wd++;
        end
        chk(done_seen, "R10 watchdog: operation finished", done_seen, 1);
        repeat (2) @(negedge clk);
        chk(done_o === 1'b0, "R10 done not repeated", done_o, 0);
        chk(timeout_o === e_to, "R10 result held", timeout_o, e_to);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
        chk(rd_req_o === 1'b0, "R1 no read after reset", rd_req_o, 0);
        chk(done_o === 1'b0, "R1 no done after reset", done_o, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy_o === 1'b0, "R1 idle without start", busy_o, 0);
        // R3 program, top bit of expected 1, hit after two busy reads
        run_op(1'b0, 16'h1234, 8'hC3, 2, 1, 1'b0, 1'b0);
        // R3 program, top bit of expected 0
        run_op(1'b0, 16'h0F0F, 8'h3C, 3, 2, 1'b0, 1'b0);
        // R4 completion on the very first status read
        run_op(1'b0, 16'h0001, 8'h81, 0, 1, 1'b0, 1'b0);
        // R5 program whose final byte differs in a low bit
        run_op(1'b0, 16'h2222, 8'h96, 1, 1, 1'b1, 1'b0);
        // R6 erase
        run_op(1'b1, 16'h8000, 8'h00, 2, 3, 1'b0, 1'b0);
        // R8 boundary: hit on the last allowed status read
        run_op(1'b1, 16'h4444, 8'h00, MAXP - 1, 1, 1'b0, 1'b0);
        // R8 timeout
        run_op(1'b0, 16'h5555, 8'h7E, MAXP + 3, 2, 1'b0, 1'b0);
        // R9 start while busy
        run_op(1'b0, 16'hABCD, 8'h5A, 2, 1, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        chk(rd_req_o === 1'b0, "R8 no read after finish", rd_req_o, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule